// File: doc/BRIEF.md
# Self-Recovering Ring-Versioned Adder Section

This block is one stage of an arithmetic pipeline. It adds two W-bit operands and a carry-in on a closed ring of W+1 identical full-adder cells. For any operation only W of the cells take part in the sum. The remaining cell is the spare, and its output never reaches the result. A version number picks the point where the carry ring is cut, and so decides which cell is the spare. An input rotator places the operand bits onto the ring to match the version, and an output rotator gathers the sum back into bit order.

In normal running the version steps forward on every accepted operation. This moves each cell through the spare slot in turn, so a stuck cell is exercised under many operand patterns. A residue-3 checker compares the registered result with the operands. When it reports a mismatch, the section keeps stepping the version on each operation until a result passes. It then locks that version, which leaves the faulty cell parked in the spare slot. The lock holds until the job ends (job_done) or a new job begins (job_start). A test port forces the sum output of a chosen physical cell to a fixed value.

Top module: `srr_adder_section`

## Requirements
- R1: With no injected fault, an operation accepted on in_valid appears on the next clock edge with out_valid high and {out_cout, out_sum} equal to in_a + in_b + in_cin.
- R2: For version V, operand bit i uses physical cell (V+i) mod (W+1), the carry-in enters cell V, and the carry-out is taken from cell (V+W-1) mod (W+1). The spare cell (V+W) mod (W+1) has no effect on the result, even when a fault is injected into it.
- R3: When unlocked and with no error, each accepted operation advances the version by one, wrapping from W back to 0. The version holds on cycles without in_valid. out_ver reports the version that was used for the result beside it.
- R4: out_err rises with the result whenever the mod-3 residue of {out_cout, out_sum} differs from the mod-3 residue of a+b+cin. A single stuck cell output that corrupts the sum is always flagged.
- R5: An operation with an error advances the version and clears the lock. The first error-free operation after one or more errors sets the lock and keeps the version unchanged.
- R6: While locked, error-free operations leave the version unchanged. An error while locked restarts the search by advancing the version.
- R7: job_done clears the lock and the search state, and the version then advances again on later operations.
- R8: job_start sets the version to 0 and clears the lock and the search state. It overrides any operation in the same cycle.
- R9: After reset the version is 0, out_locked is low and out_valid is low.
- R10: With one persistent stuck cell and operands that expose it, a correct result returns within W+1 operations, and the version then stays fixed on every later operation.
- R11: out_locked shows the lock state after the operation that was just registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cin | input | 1 | Carry-in |
| job_start | input | 1 | Start of job: version to 0, lock cleared |
| job_done | input | 1 | End of job: lock released |
| flt_en | input | 1 | Enable stuck-value injection |
| flt_cell | input | $clog2(W+1) | Physical cell whose sum output is forced |
| flt_val | input | 1 | Forced value |
| out_valid | output | 1 | Result valid |
| out_sum | output | W | Sum |
| out_cout | output | 1 | Carry-out |
| out_err | output | 1 | Residue check mismatch for this result |
| out_ver | output | $clog2(W+1) | Version used for this result |
| out_locked | output | 1 | Version lock state |

## Verification
The bench uses W = 8, which gives a ring of nine cells. This makes the version wrap at a value that is not a power of two and lets each of the nine physical cells be faulted. A behavioural model tracks the version, search and lock state with integers. It predicts any corrupted sum by forcing the bit whose logical position the faulty cell holds under the current version. This covers faults that stay silent because the forced value matches the true bit, and locks that are reached by luck before the spare slot is hit. Separate scenarios cover a fault in the spare cell, recovery from an all-zero exposing pattern, relocating the fault while locked, and job_start or job_done arriving in the same cycle as an operation.

// File: rtl/srr_pkg.sv
package srr_pkg;
  // residue modulo 3 of an unsigned value up to 64 bits
  function automatic logic [1:0] res3(input logic [63:0] v);
    return 2'(v % 64'd3);
  endfunction

  // residue of a sum of two residues and a carry bit
  function automatic logic [1:0] res3_add(input logic [1:0] x, input logic [1:0] y,
                                          input logic c);
    logic [2:0] t;
    t = 3'(x) + 3'(y) + 3'(c);
    return 2'(t % 3'd3);
  endfunction
endpackage

// File: rtl/srr_ring.sv
module srr_ring #(
  parameter int W  = 8,
  parameter int N  = W + 1,
  parameter int VW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] ver,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  input  logic          flt_en,
  input  logic [VW-1:0] flt_cell,
  input  logic          flt_val,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic [N-1:0]  brk
);
  logic [N-1:0] ext_a, ext_b, ring_a, ring_b, cell_s, cell_co;

  assign ext_a = {1'b0, a};
  assign ext_b = {1'b0, b};

  // break units: one-hot decode of the version
  for (genvar c = 0; c < N; c++) begin : g_brk
    assign brk[c] = (ver == VW'(c));
  end

  // input rotator: ring cell c receives extended operand bit (c - ver) mod N
  always_comb begin
    for (int c = 0; c < N; c++) begin
      logic [VW-1:0] p;
      p = VW'((c + N - int'(ver)) % N);
      ring_a[c] = ext_a[p];
      ring_b[c] = ext_b[p];
    end
  end

  // carry chain, walked in logical order from the cut point
  always_comb begin
    logic carry;
    logic ci;
    carry   = 1'b0;
    cell_s  = '0;
    cell_co = '0;
    for (int k = 0; k < N; k++) begin
      logic [VW-1:0] c;
      c  = VW'((int'(ver) + k) % N);
      ci = brk[c] ? cin : carry;
      cell_s[c]  = (flt_en && flt_cell == c) ? flt_val : (ring_a[c] ^ ring_b[c] ^ ci);
      carry      = (ring_a[c] & ring_b[c]) | (ci & (ring_a[c] ^ ring_b[c]));
      cell_co[c] = carry;
    end
  end

  // output rotator and carry-out tap
  always_comb begin
    logic [VW-1:0] t;
    for (int i = 0; i < W; i++) begin
      logic [VW-1:0] q;
      q = VW'((int'(ver) + i) % N);
      sum[i] = cell_s[q];
    end
    t    = VW'((int'(ver) + W - 1) % N);
    cout = cell_co[t];
  end

  // R2: exactly one break unit cuts the ring
  a_r2_one_cut: assert property (@(posedge clk) disable iff (!rst_n) $onehot(brk));
endmodule

// File: rtl/srr_check.sv
module srr_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [W-1:0] sum,
  input  logic         cout,
  output logic         err
);
  import srr_pkg::*;
  logic [1:0] r_in, r_out;

  assign r_in  = res3_add(res3(64'(a)), res3(64'(b)), cin);
  assign r_out = res3(64'({cout, sum}));
  assign err   = (r_in != r_out);
endmodule

// File: rtl/srr_ctrl.sv
module srr_ctrl #(
  parameter int N  = 9,
  parameter int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_err,
  input  logic          job_start,
  input  logic          job_done,
  output logic [VW-1:0] ver,
  output logic          locked
);
  logic          srch;
  logic [VW-1:0] ver_inc, ver_n;
  logic          lock_n, srch_n;

  assign ver_inc = (ver == VW'(N - 1)) ? '0 : ver + 1'b1;

  always_comb begin
    ver_n  = ver;
    lock_n = locked;
    srch_n = srch;
    if (op_valid) begin
      if (op_err) begin
        ver_n  = ver_inc;
        srch_n = 1'b1;
        lock_n = 1'b0;
      end else if (srch) begin
        lock_n = 1'b1;
        srch_n = 1'b0;
      end else if (!locked) begin
        ver_n = ver_inc;
      end
    end
    if (job_done) begin
      lock_n = 1'b0;
      srch_n = 1'b0;
    end
    if (job_start) begin
      ver_n  = '0;
      lock_n = 1'b0;
      srch_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver    <= '0;
      locked <= 1'b0;
      srch   <= 1'b0;
    end else begin
      ver    <= ver_n;
      locked <= lock_n;
      srch   <= srch_n;
    end
  end

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !job_start |=> (ver == $past(ver)) || (ver == $past(ver_inc)));
  a_r5_err_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_err && !job_start) |=> (ver == $past(ver_inc)) && !locked);
  a_r5_lock_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_err && srch && !job_start && !job_done) |=> locked && $stable(ver));
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !job_start && !(op_valid && op_err)) |=> $stable(ver));
  a_r7_done_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !locked);
  a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> (ver == '0) && !locked);
endmodule

// File: rtl/srr_adder_section.sv
module srr_adder_section #(
  parameter int W  = 8,
  parameter int N  = W + 1,
  parameter int VW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic          in_cin,
  input  logic          job_start,
  input  logic          job_done,
  input  logic          flt_en,
  input  logic [VW-1:0] flt_cell,
  input  logic          flt_val,
  output logic          out_valid,
  output logic [W-1:0]  out_sum,
  output logic          out_cout,
  output logic          out_err,
  output logic [VW-1:0] out_ver,
  output logic          out_locked
);
  logic [VW-1:0] ver;
  logic [N-1:0]  brk;
  logic [W-1:0]  ring_sum;
  logic          ring_cout, chk_err, locked;
  logic [VW-1:0] spare_cell;

  assign spare_cell = (ver == '0) ? VW'(N - 1) : ver - 1'b1;

  srr_ring #(.W(W), .N(N), .VW(VW)) u_ring (
    .clk(clk), .rst_n(rst_n), .ver(ver), .a(in_a), .b(in_b), .cin(in_cin),
    .flt_en(flt_en), .flt_cell(flt_cell), .flt_val(flt_val),
    .sum(ring_sum), .cout(ring_cout), .brk(brk)
  );

  srr_check #(.W(W)) u_chk (
    .a(in_a), .b(in_b), .cin(in_cin), .sum(ring_sum), .cout(ring_cout), .err(chk_err)
  );

  srr_ctrl #(.N(N), .VW(VW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(in_valid), .op_err(chk_err),
    .job_start(job_start), .job_done(job_done), .ver(ver), .locked(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_cout  <= 1'b0;
      out_err   <= 1'b0;
      out_ver   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum  <= ring_sum;
        out_cout <= ring_cout;
        out_err  <= chk_err;
        out_ver  <= ver;
      end
    end
  end

  assign out_locked = locked;

  a_r1_clean_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flt_en) |=> out_valid && ({out_cout, out_sum} ==
      $past({1'b0, in_a} + {1'b0, in_b} + (W+1)'(in_cin))));
  a_r2_spare_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flt_en && flt_cell == spare_cell) |=> !out_err);
  a_r4_err_flags_wrong: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_err == ({out_cout, out_sum} !=
      $past({1'b0, in_a} + {1'b0, in_b} + (W+1)'(in_cin))));
endmodule

// File: tb/tb_srr_adder_section.sv
module tb_srr_adder_section;
  localparam int W  = 8;
  localparam int N  = W + 1;
  localparam int VW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_cin = 1'b0, job_start = 1'b0, job_done = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic flt_en = 1'b0, flt_val = 1'b0;
  logic [VW-1:0] flt_cell = '0;
  logic out_valid, out_cout, out_err, out_locked;
  logic [W-1:0] out_sum;
  logic [VW-1:0] out_ver;

  int n_vec = 0, n_bad = 0;
  int m_ver = 0, m_lock = 0, m_srch = 0;
  logic seen_err;

  always #5 clk = ~clk;

  srr_adder_section #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .job_start(job_start), .job_done(job_done),
    .flt_en(flt_en), .flt_cell(flt_cell), .flt_val(flt_val),
    .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout),
    .out_err(out_err), .out_ver(out_ver), .out_locked(out_locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one clock: drive, predict, sample after the edge, update the model
  task automatic step(input logic v, input int a, input int b, input logic c,
                      input logic js, input logic jd);
    int tru, got, k, e_err, ver_used;
    @(negedge clk);
    in_valid = v; in_a = W'(a); in_b = W'(b); in_cin = c;
    job_start = js; job_done = jd;
    tru = a + b + int'(c);
    got = tru;
    if (flt_en) begin
      k = (int'(flt_cell) - m_ver + N) % N;   // logical slot of the faulty cell
      if (k < W) begin
        if (flt_val) got = tru | (1 << k);
        else         got = tru & ~(1 << k);
      end
    end
    e_err = (got != tru);
    ver_used = m_ver;
    // reference model of version control
    if (js) begin
      m_ver = 0; m_lock = 0; m_srch = 0;
    end else begin
      if (v) begin
        if (e_err != 0) begin m_ver = (m_ver + 1) % N; m_srch = 1; m_lock = 0; end
        else if (m_srch != 0) begin m_lock = 1; m_srch = 0; end
        else if (m_lock == 0) m_ver = (m_ver + 1) % N;
      end
      if (jd) begin m_lock = 0; m_srch = 0; end
    end
    @(posedge clk); #1;
    chk("R1 out_valid", int'(out_valid), int'(v));
    if (v) begin
      chk("R1/R2 result", int'({out_cout, out_sum}), got);
      chk("R4 out_err", int'(out_err), e_err);
      chk("R3 out_ver", int'(out_ver), ver_used);
      seen_err = out_err;
    end
    chk("R11 out_locked", int'(out_locked), m_lock);
    in_valid = 1'b0; job_start = 1'b0; job_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cnt, held;
    seen_err = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R9 out_locked after reset", int'(out_locked), 0);
    rst_n = 1'b1;
    step(1'b1, 3, 4, 1'b0, 1'b0, 1'b0);        // R9: first op uses version 0
    // R1 R3: random clean ops across several wraps
    for (int i = 0; i < 30; i++)
      step(1'b1, int'($urandom_range(255)), int'($urandom_range(255)), 1'($urandom_range(1)), 1'b0, 1'b0);
    step(1'b1, 255, 255, 1'b1, 1'b0, 1'b0);    // R1 maximum sum
    // R3 idle cycles hold the version
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1, 1, 1'b0, 1'b0, 1'b0);
    // R2 fault in the spare cell is masked
    flt_en = 1'b1; flt_val = 1'b1;
    for (int i = 0; i < 5; i++) begin
      flt_cell = VW'((m_ver + W) % N);
      step(1'b1, 0, 0, 1'b0, 1'b0, 1'b0);
      chk("R2 spare fault masked", int'(out_err), 0);
    end
    // R10 persistent fault on an active cell, exposing pattern a=b=0
    flt_cell = VW'((m_ver + 2) % N);
    cnt = 0;
    seen_err = 1'b1;
    while (seen_err && cnt < N + 2) begin
      step(1'b1, 0, 0, 1'b0, 1'b0, 1'b0);
      cnt++;
    end
    chk("R10 recovered within W+1 ops", int'(cnt <= N), 1);
    chk("R5 locked after first pass", int'(out_locked), 1);
    held = int'(out_ver);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, int'($urandom_range(255)), int'($urandom_range(255)), 1'b0, 1'b0, 1'b0);
      chk("R6/R10 version frozen", int'(out_ver), held);
    end
    // R6 fault moves while locked: search restarts
    flt_cell = VW'((m_ver + 4) % N);
    for (int i = 0; i < 2 * N; i++) step(1'b1, 0, 0, 1'b0, 1'b0, 1'b0);
    chk("R6 relocked after moved fault", int'(out_locked), 1);
    // R7 job_done with an op in the same cycle, then advance resumes
    step(1'b1, 5, 6, 1'b0, 1'b0, 1'b1);
    chk("R7 unlocked by job_done", int'(out_locked), 0);
    flt_en = 1'b0;
    held = m_ver;
    step(1'b1, 7, 8, 1'b1, 1'b0, 1'b0);
    chk("R7 version used after release", int'(out_ver), held);
    step(1'b1, 9, 9, 1'b0, 1'b0, 1'b0);
    chk("R7 version advancing again", int'(out_ver), (held + 1) % N);
    // R8 job_start overrides an op in the same cycle
    step(1'b1, 100, 27, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1, 2, 1'b0, 1'b0, 1'b0);
    chk("R8 version zero after job_start", int'(out_ver), 0);
    // mixed random run with random faults and job boundaries
    for (int i = 0; i < 300; i++) begin
      flt_en   = ($urandom_range(3) == 0);
      flt_cell = VW'($urandom_range(N - 1));
      flt_val  = 1'($urandom_range(1));
      step(1'($urandom_range(4) != 0), int'($urandom_range(255)), int'($urandom_range(255)),
           1'($urandom_range(1)), ($urandom_range(40) == 0), ($urandom_range(20) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule